// File: doc/BRIEF.md
# Nibble-Accessed 10-bit Up/Down Event Counter

The block is a 10-bit programmable counter that a 4-bit processor drives through a small register file. Software writes a start value in three pieces (two 4-bit nibbles and a 2-bit top field), selects direction, count clock and counting span, then pulses a load bit. That bit copies the value into the live counter. With the start bit set, the counter steps once for every rising edge of the chosen clock source. It pulses an interrupt request when it arrives at its terminal value.

The clock source is one of eight: two port pins or six prescaler taps. Sources are sampled in the system clock domain and edge-detected, so every source acts as a count enable. A read of the low count nibble freezes the upper six bits in a shadow register, so the three reads of a 10-bit value are coherent. Changing the direction replaces the live count by its bitwise inverse. Loading zero acts as a stop command.

Register map (3-bit address): 0 = low data nibble on write, live count[3:0] on read. 1 = middle data nibble on write, shadow of count[7:4] on read. 2 = top data field (wdata[1:0]) on write, shadow of count[9:8] in rdata[1:0] on read. 3 = mode: bit 3 direction (1 = up), bits 2:0 clock select. 4 = control: bit 0 load (self-clearing, reads 0), bit 1 start, bits 3:2 span (00 = 10 bits, 01 = 8, 10 = 6, 11 = 4).

Top module: `ud_event_counter`

## Requirements
- R1: Writing control with bit 0 set copies {top[1:0], middle, low} into the count on that clock edge; control bit 0 always reads back 0.
- R2: A read at address 0 returns live count[3:0] and captures count[9:4]; later reads at addresses 1 and 2 return that capture even if the count has moved since.
- R3: In up mode (mode bit 3 = 1) each rising edge of the selected source while start is 1 adds one; irq_o pulses for one cycle on the step that makes the spanned bits all ones, and the next step wraps them to 0.
- R4: In down mode each qualifying edge subtracts one; irq_o pulses for one cycle on the step that makes the spanned bits zero, and the next step wraps them to all ones.
- R5: With a span below 10 bits, only the low 8, 6 or 4 bits count and set the terminal value; the bits above hold their value.
- R6: A load never raises irq_o, even when the loaded value equals the terminal value.
- R7: A mode write whose bit 3 differs from the current direction replaces the count by its bitwise inverse, without an interrupt.
- R8: A load of value 0 clears start, whatever start value the same write carries, and raises no interrupt.
- R9: Clock select 0 uses pin0_i, 7 uses pin3_i, and values 1 to 6 use presc_taps_i[0] to presc_taps_i[5] (taps 15, 12, 10, 8, 4, 1); no other source moves the count.
- R10: After reset the mode and control registers read 0 (down, select 0, 10-bit span, stopped), the count is 0 and irq_o is low.
- R11: While start is 0, source edges leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (address 0 captures shadow) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 4 | Write data |
| rdata_o | output | 4 | Read data for addr_i |
| pin0_i | input | 1 | Port pin source, select 0 |
| pin3_i | input | 1 | Port pin source, select 7 |
| presc_taps_i | input | 6 | Prescaler taps 15, 12, 10, 8, 4, 1 for selects 1 to 6 |
| irq_o | output | 1 | One-cycle terminal-count interrupt pulse |

## Verification
On every cycle, assertions check these rules: a load copies the assembled value and stays silent, a direction flip inverts the count, the count holds when no step, load or flip occurs, an interrupt follows only a step, a zero load stops the counter, and a low-nibble read captures the upper bits. Other behaviour needs the directed scenarios: where the terminal value falls in each span, the wrap after an interrupt, the mapping of all eight clock sources, and the coherence of a split read across a carry.

// File: rtl/ud_cnt_pkg.sv
package ud_cnt_pkg;
  localparam int CNT_W = 10;
  localparam int NIB_W = 4;
  localparam int SEL_W = 3;
  localparam int SPAN_W = 2;

  localparam logic [2:0] ADR_DLO  = 3'd0;
  localparam logic [2:0] ADR_DMID = 3'd1;
  localparam logic [2:0] ADR_DHI  = 3'd2;
  localparam logic [2:0] ADR_MODE = 3'd3;
  localparam logic [2:0] ADR_CTRL = 3'd4;

  localparam int CTL_LOAD  = 0;
  localparam int CTL_START = 1;
  localparam int MODE_DIR  = 3;
endpackage

// File: rtl/ud_cnt_clksel.sv
module ud_cnt_clksel
  import ud_cnt_pkg::*;
#(
  parameter int SW = SEL_W,
  localparam int NSRC = 1 << SW,
  localparam int NTAP = NSRC - 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [SW-1:0]   sel_i,
  input  logic            run_i,
  input  logic            pin0_i,
  input  logic            pin3_i,
  input  logic [NTAP-1:0] taps_i,
  output logic            tick_o
);
  logic [NSRC-1:0] src_vec;
  logic            src, lvl_q;

  assign src_vec = {pin3_i, taps_i, pin0_i};
  assign src     = src_vec[sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= src;
  end

  assign tick_o = run_i & src & ~lvl_q;

  p_tick_run_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> run_i);
endmodule

// File: rtl/ud_cnt_regs.sv
module ud_cnt_regs
  import ud_cnt_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int NW = NIB_W,
  parameter int SW = SEL_W,
  parameter int PW = SPAN_W,
  localparam int HW  = CW - 2 * NW,
  localparam int SHW = CW - NW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [2:0]    addr_i,
  input  logic [NW-1:0] wdata_i,
  input  logic [CW-1:0] count_i,
  output logic [NW-1:0] rdata_o,
  output logic [CW-1:0] creg_o,
  output logic          load_o,
  output logic          flip_o,
  output logic          dir_up_o,
  output logic          run_o,
  output logic [SW-1:0] sel_o,
  output logic [PW-1:0] span_o
);
  logic [NW-1:0]  lo_q, mid_q;
  logic [HW-1:0]  hi_q;
  logic [SHW-1:0] shadow_q;
  logic           dir_q, start_q;
  logic [SW-1:0]  sel_q;
  logic [PW-1:0]  span_q;
  logic           wr_mode, wr_ctrl, snap;

  assign wr_mode = wr_en_i && (addr_i == ADR_MODE);
  assign wr_ctrl = wr_en_i && (addr_i == ADR_CTRL);
  assign snap    = rd_en_i && (addr_i == ADR_DLO);
  assign creg_o  = {hi_q, mid_q, lo_q};
  assign load_o  = wr_ctrl && wdata_i[CTL_LOAD];
  assign flip_o  = wr_mode && (wdata_i[MODE_DIR] != dir_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q     <= '0;
      mid_q    <= '0;
      hi_q     <= '0;
      dir_q    <= 1'b0;
      sel_q    <= '0;
      span_q   <= '0;
      start_q  <= 1'b0;
      shadow_q <= '0;
    end else begin
      if (wr_en_i && addr_i == ADR_DLO)  lo_q  <= wdata_i;
      if (wr_en_i && addr_i == ADR_DMID) mid_q <= wdata_i;
      if (wr_en_i && addr_i == ADR_DHI)  hi_q  <= wdata_i[HW-1:0];
      if (wr_mode) begin
        dir_q <= wdata_i[MODE_DIR];
        sel_q <= wdata_i[SW-1:0];
      end
      if (wr_ctrl) begin
        span_q  <= wdata_i[NW-1 -: PW];
        // zero load doubles as stop
        start_q <= wdata_i[CTL_START] && !(load_o && creg_o == '0);
      end
      if (snap) shadow_q <= count_i[CW-1:NW];
    end
  end

  always_comb begin
    unique case (addr_i)
      ADR_DLO:  rdata_o = count_i[NW-1:0];
      ADR_DMID: rdata_o = shadow_q[NW-1:0];
      ADR_DHI:  rdata_o = NW'(shadow_q[SHW-1:NW]);
      ADR_MODE: rdata_o = {dir_q, sel_q};
      ADR_CTRL: rdata_o = {span_q, start_q, 1'b0};
      default:  rdata_o = '0;
    endcase
  end

  assign dir_up_o = dir_q;
  assign run_o    = start_q;
  assign sel_o    = sel_q;
  assign span_o   = span_q;

  p_shadow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap |=> shadow_q == $past(count_i[CW-1:NW]));
  p_zero_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && creg_o == '0) |=> !start_q);
  p_load_rd0_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADR_CTRL) |-> !rdata_o[CTL_LOAD]);
endmodule

// File: rtl/ud_cnt_core.sv
module ud_cnt_core
  import ud_cnt_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int PW = SPAN_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          flip_i,
  input  logic          tick_i,
  input  logic          dir_up_i,
  input  logic [PW-1:0] span_i,
  output logic [CW-1:0] count_o,
  output logic          irq_o
);
  logic [CW-1:0] cnt_q, mask, stepped, nxt;
  logic          hit;

  always_comb begin
    mask    = {CW{1'b1}} >> {span_i, 1'b0};
    stepped = dir_up_i ? cnt_q + 1'b1 : cnt_q - 1'b1;
    nxt     = (cnt_q & ~mask) | (stepped & mask);
    hit     = dir_up_i ? ((nxt & mask) == mask) : ((nxt & mask) == '0);
  end

  // priority: load, then direction flip, then step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (load_i)      cnt_q <= load_val_i;
      else if (flip_i) cnt_q <= ~cnt_q;
      else if (tick_i) begin
        cnt_q <= nxt;
        irq_o <= hit;
      end
    end
  end

  assign count_o = cnt_q;

  p_load_copy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
  p_load_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !irq_o);
  p_flip_inv_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flip_i && !load_i) |=> (cnt_q == ~$past(cnt_q)) && !irq_o);
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i && !flip_i) |=> $stable(cnt_q) && !irq_o);
  p_irq_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(tick_i));
endmodule

// File: rtl/ud_event_counter.sv
module ud_event_counter
  import ud_cnt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [2:0]       addr_i,
  input  logic [NIB_W-1:0] wdata_i,
  output logic [NIB_W-1:0] rdata_o,
  input  logic             pin0_i,
  input  logic             pin3_i,
  input  logic [5:0]       presc_taps_i,
  output logic             irq_o
);
  logic [CNT_W-1:0]  count, creg;
  logic              load, flip, dir_up, run, tick;
  logic [SEL_W-1:0]  sel;
  logic [SPAN_W-1:0] span;

  ud_cnt_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i,
    .count_i(count), .rdata_o, .creg_o(creg), .load_o(load),
    .flip_o(flip), .dir_up_o(dir_up), .run_o(run), .sel_o(sel),
    .span_o(span)
  );

  ud_cnt_clksel u_clksel (
    .clk_i, .rst_ni, .sel_i(sel), .run_i(run), .pin0_i, .pin3_i,
    .taps_i(presc_taps_i), .tick_o(tick)
  );

  ud_cnt_core u_core (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(creg), .flip_i(flip),
    .tick_i(tick), .dir_up_i(dir_up), .span_i(span), .count_o(count),
    .irq_o
  );
endmodule

// File: tb/tb_ud_event_counter.sv
module tb_ud_event_counter;
  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, rd_en = 0, pin0 = 0, pin3 = 0;
  logic [2:0] addr = 0;
  logic [3:0] wdata = 0, rdata;
  logic [5:0] taps = 0;
  logic       irq;
  int checks = 0, errors = 0, irq_seen = 0;
  bit done = 0;

  ud_event_counter dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pin0_i(pin0),
    .pin3_i(pin3), .presc_taps_i(taps), .irq_o(irq)
  );

  always #5 clk = ~clk;
  always @(negedge clk) if (rst_n && irq) irq_seen++;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [3:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [3:0] d);
    @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic rd_count(output logic [9:0] v);
    logic [3:0] a, b, c;
    rd(0, a); rd(1, b); rd(2, c);
    v = {c[1:0], b, a};
  endtask

  task automatic set_src(int s, logic v);
    if (s == 0) pin0 = v;
    else if (s == 7) pin3 = v;
    else taps[s-1] = v;
  endtask

  task automatic pulse(int s);
    @(negedge clk); set_src(s, 1);
    @(negedge clk); set_src(s, 0);
    @(negedge clk);
  endtask

  task automatic load(logic [9:0] v, logic [3:0] ctl);
    wr(0, v[3:0]); wr(1, v[7:4]); wr(2, {2'b0, v[9:8]});
    wr(4, ctl);
  endtask

  task automatic t_reset;
    logic [3:0] d; logic [9:0] v;
    rd(3, d); chk("R10 mode", d, 0);
    rd(4, d); chk("R10 ctrl", d, 0);
    rd_count(v); chk("R10 count", v, 0);
    chk("R10 irq", irq, 0);
  endtask

  task automatic t_load;
    logic [3:0] d; logic [9:0] v;
    wr(3, 4'b1000);
    load(10'h2A5, 4'b0001);
    rd_count(v); chk("R1 loaded", v, 'h2A5);
    rd(4, d); chk("R1 load bit self-clears", d[0], 0);
  endtask

  task automatic t_up;
    logic [9:0] v; int i0;
    wr(3, 4'b1000); load(10'h3FD, 4'b0011);
    i0 = irq_seen;
    pulse(0); chk("R3 no irq before terminal", irq_seen - i0, 0);
    pulse(0); chk("R3 irq at 3FF", irq_seen - i0, 1);
    rd_count(v); chk("R3 count 3FF", v, 'h3FF);
    pulse(0); rd_count(v); chk("R3 wrap to 0", v, 0);
    chk("R3 single irq", irq_seen - i0, 1);
  endtask

  task automatic t_down;
    logic [9:0] v; int i0;
    wr(3, 4'b0000); load(10'h002, 4'b0011);
    i0 = irq_seen;
    pulse(0); rd_count(v); chk("R4 step down", v, 1);
    chk("R4 no irq at 1", irq_seen - i0, 0);
    pulse(0); chk("R4 irq at zero", irq_seen - i0, 1);
    pulse(0); rd_count(v); chk("R4 wrap to 3FF", v, 'h3FF);
  endtask

  task automatic t_span;
    logic [9:0] v; int i0;
    wr(3, 4'b1000); load(10'h1FD, 4'b0111);
    i0 = irq_seen;
    pulse(0); pulse(0); chk("R5 irq at FF in 8-bit span", irq_seen - i0, 1);
    pulse(0); rd_count(v); chk("R5 upper bits kept", v, 'h100);
    load(10'h20E, 4'b1111);
    i0 = irq_seen;
    pulse(0); chk("R5 irq at F in 4-bit span", irq_seen - i0, 1);
    rd_count(v); chk("R5 4-bit value", v, 'h20F);
    wr(4, 4'b0000);
  endtask

  task automatic t_load_quiet;
    int i0 = irq_seen;
    wr(3, 4'b1000); load(10'h3FF, 4'b0011);
    wr(3, 4'b1000); load(10'h3FF, 4'b0001);
    chk("R6 load of terminal value no irq", irq_seen - i0, 0);
  endtask

  task automatic t_flip;
    logic [9:0] v; int i0;
    wr(3, 4'b1000); load(10'h123, 4'b0001);
    i0 = irq_seen;
    wr(3, 4'b0000); rd_count(v); chk("R7 inverted", v, 'h2DC);
    wr(3, 4'b0000); rd_count(v); chk("R7 same dir no invert", v, 'h2DC);
    chk("R7 no irq", irq_seen - i0, 0);
  endtask

  task automatic t_zero_stop;
    logic [3:0] d; logic [9:0] v; int i0;
    wr(3, 4'b0000); i0 = irq_seen;
    load(10'h000, 4'b0011);
    rd(4, d); chk("R8 start cleared", d[1], 0);
    pulse(0); rd_count(v); chk("R8 stopped", v, 0);
    chk("R8 no irq", irq_seen - i0, 0);
  endtask

  task automatic t_stopped;
    logic [9:0] v;
    wr(3, 4'b1000); load(10'h050, 4'b0001);
    pulse(0); pulse(0); rd_count(v); chk("R11 no count when stopped", v, 'h050);
  endtask

  task automatic t_shadow;
    logic [3:0] a, b, c; logic [9:0] v;
    wr(3, 4'b1000); load(10'h0FF, 4'b0011);
    rd(0, a); pulse(0); rd(1, b); rd(2, c);
    chk("R2 coherent read", {c[1:0], b, a}, 'h0FF);
    rd_count(v); chk("R2 fresh read", v, 'h100);
    wr(4, 4'b0000);
  endtask

  task automatic t_clksel;
    logic [9:0] v;
    for (int s = 0; s < 8; s++) begin
      wr(3, {1'b1, 3'(s)}); load(10'h010, 4'b0011);
      pulse((s + 1) % 8); rd_count(v);
      chk($sformatf("R9 sel %0d ignores other source", s), v, 'h010);
      pulse(s); rd_count(v);
      chk($sformatf("R9 sel %0d counts own source", s), v, 'h011);
    end
    wr(4, 4'b0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_load; t_up; t_down; t_span; t_load_quiet;
    t_flip; t_zero_stop; t_stopped; t_shadow; t_clksel;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule